// File: doc/BRIEF.md
# Byte-Masked Quad-Word Store Unit

This unit sits on a processor's store path. It takes one 64-bit value, a target address and a selector operand, and turns them into a single write on a byte-addressed memory port. The write carries eight per-byte enables. A 2-bit mode picks how those enables are formed. A plain store writes the whole quad-word. An explicit 8-bit mask enables bytes one by one. An inverted form looks at bit 0 of each selector byte. A leading-count form writes only the first N bytes.

The value is big-endian. Its most significant byte goes to the lowest address and its least significant byte goes to the highest. The selector is interpreted in the same order. Bytes whose enable is clear are not driven, so memory keeps their earlier contents. A masked store can therefore drop a 24-bit pixel into the tail of a word, or update a few fields, without a read-modify-write.

A request is taken in one cycle when the unit is ready. The unit then holds address, data and enables on the port until the port acknowledges. One cycle after the acknowledge it pulses done. Address generation happens upstream, and the address is passed through unchanged.

Top module: `qstore_unit`

## Requirements
- R1: In mode 0 (plain), all eight byte enables are set and every byte of the value is written.
- R2: Port lane i is the byte at address offset i. Lane i carries value byte 7-i, so bits 63:56 go to offset 0 and bits 7:0 go to offset 7.
- R3: In mode 1 (masked), lane i is enabled by selector bit 7-i. Bit 7 selects the lowest-address byte and bit 0 selects the highest.
- R4: In mode 2 (inverted), lane i is enabled when bit 0 of selector byte 7-i is zero. Selector byte k is bits 8k+7:8k.
- R5: In mode 3 (count), lanes 0 to N-1 are enabled, where N is the unsigned selector value. N of 8 or more enables all lanes, and N of 0 enables none.
- R6: Bytes whose lane enable is clear keep their previous memory contents.
- R7: While the memory request is high and not acknowledged, the address, write data and byte enables stay stable and the request stays high.
- R8: Done is high for exactly one cycle. That cycle is the one right after the cycle in which the request was acknowledged, and the request is low in that cycle.
- R9: Ready is high only when no request is outstanding on the memory port. A request is accepted on a cycle where valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Store request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_mode_i | input | 2 | 0 plain, 1 masked, 2 inverted, 3 count |
| req_addr_i | input | AW | Quad-word address |
| req_data_i | input | 64 | Value to store, big-endian |
| req_sel_i | input | 64 | Mask, inverted mask or byte count |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Write address |
| mem_wdata_o | output | 64 | Write data, lane i at bits 8i+7:8i |
| mem_be_o | output | 8 | Byte enable per lane |
| mem_ack_i | input | 1 | Memory accepted the write |
| done_o | output | 1 | Store finished, one-cycle pulse |

## Verification
The bench tests the lane mapping with asymmetric masks such as 0xB7 and 0x07. A design with reversed bit order would write the wrong half of the word, and the memory image would show it. The count mode is tested at 0, at 3, 6 and 8, and at values far above 8. An off-by-one design writes one byte too many or too few, and a design that truncates the count wraps large values to partial stores. Memory is pre-filled with a pattern so that a design which zeroes disabled bytes is caught. Acknowledge latency is random, which exposes a request that drifts while the port is stalled or a done pulse that arrives early or lasts too long.

// File: rtl/qstore_pkg.sv
package qstore_pkg;
    typedef enum logic [1:0] {
        QS_PLAIN  = 2'd0,
        QS_MASK   = 2'd1,
        QS_INVLSB = 2'd2,
        QS_COUNT  = 2'd3
    } qs_mode_e;
endpackage

// File: rtl/qstore_be_gen.sv
// Byte-enable generation, lane i = address offset i (big-endian value).
module qstore_be_gen
    import qstore_pkg::*;
#(
    parameter int LANES = 8
) (
    input  qs_mode_e               mode_i,
    input  logic [LANES*8-1:0]     sel_i,
    output logic [LANES-1:0]       be_o
);
    localparam int SELW = LANES * 8;

    logic [LANES-1:0] be_mask;
    logic [LANES-1:0] be_inv;
    logic [LANES-1:0] be_cnt;
    logic             cnt_all;

    assign cnt_all = (sel_i >= SELW'(LANES));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // R3: highest selector bit maps to lowest address lane
        assign be_mask[g] = sel_i[LANES-1-g];
        // R4: complement of bit 0 of the matching selector byte
        assign be_inv[g]  = ~sel_i[8*(LANES-1-g)];
        // R5: leading-byte count, saturating at LANES
        assign be_cnt[g]  = cnt_all | (SELW'(g) < sel_i);
    end

    always_comb begin
        unique case (mode_i)
            QS_PLAIN:  be_o = {LANES{1'b1}};
            QS_MASK:   be_o = be_mask;
            QS_INVLSB: be_o = be_inv;
            QS_COUNT:  be_o = be_cnt;
            default:   be_o = '0;
        endcase
    end
endmodule

// File: rtl/qstore_lane_order.sv
// Reverses byte order so the value's MSB lands at the lowest address lane.
module qstore_lane_order #(
    parameter int LANES = 8
) (
    input  logic [LANES*8-1:0] value_i,
    output logic [LANES*8-1:0] lanes_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_swap
        assign lanes_o[8*g +: 8] = value_i[8*(LANES-1-g) +: 8];
    end
endmodule

// File: rtl/qstore_issue.sv
// Single-beat write issue: capture, hold until ack, pulse done.
module qstore_issue #(
    parameter int AW    = 32,
    parameter int LANES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [LANES*8-1:0]  wdata_i,
    input  logic [LANES-1:0]    be_i,
    input  logic                mem_ack_i,
    output logic                ready_o,
    output logic                mem_req_o,
    output logic [AW-1:0]       mem_addr_o,
    output logic [LANES*8-1:0]  mem_wdata_o,
    output logic [LANES-1:0]    mem_be_o,
    output logic                done_o
);
    typedef struct packed {
        logic               busy;
        logic               done;
        logic [AW-1:0]      addr;
        logic [LANES*8-1:0] wdata;
        logic [LANES-1:0]   be;
    } issue_t;

    issue_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (mem_ack_i) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (start_i) begin
            st_d.busy  = 1'b1;
            st_d.addr  = addr_i;
            st_d.wdata = wdata_i;
            st_d.be    = be_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o     = ~st_q.busy;
    assign mem_req_o   = st_q.busy;
    assign mem_addr_o  = st_q.addr;
    assign mem_wdata_o = st_q.wdata;
    assign mem_be_o    = st_q.be;
    assign done_o      = st_q.done;
endmodule

// File: rtl/qstore_unit.sv
module qstore_unit
    import qstore_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LANES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic [1:0]          req_mode_i,
    input  logic [AW-1:0]       req_addr_i,
    input  logic [LANES*8-1:0]  req_data_i,
    input  logic [LANES*8-1:0]  req_sel_i,
    output logic                mem_req_o,
    output logic [AW-1:0]       mem_addr_o,
    output logic [LANES*8-1:0]  mem_wdata_o,
    output logic [LANES-1:0]    mem_be_o,
    input  logic                mem_ack_i,
    output logic                done_o
);
    logic [LANES-1:0]   be_w;
    logic [LANES*8-1:0] lanes_w;
    logic               ready_w;

    qstore_be_gen #(.LANES(LANES)) u_be_gen (
        .mode_i (qs_mode_e'(req_mode_i)),
        .sel_i  (req_sel_i),
        .be_o   (be_w)
    );

    qstore_lane_order #(.LANES(LANES)) u_lane_order (
        .value_i (req_data_i),
        .lanes_o (lanes_w)
    );

    qstore_issue #(.AW(AW), .LANES(LANES)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (req_valid_i & ready_w),
        .addr_i      (req_addr_i),
        .wdata_i     (lanes_w),
        .be_i        (be_w),
        .mem_ack_i   (mem_ack_i),
        .ready_o     (ready_w),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_be_o    (mem_be_o),
        .done_o      (done_o)
    );

    assign req_ready_o = ready_w;
endmodule

// File: rtl/qstore_unit_chk.sv
module qstore_unit_chk #(
    parameter int AW    = 32,
    parameter int LANES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid_i,
    input logic                req_ready_o,
    input logic [1:0]          req_mode_i,
    input logic [LANES*8-1:0]  req_sel_i,
    input logic                mem_req_o,
    input logic [AW-1:0]       mem_addr_o,
    input logic [LANES*8-1:0]  mem_wdata_o,
    input logic [LANES-1:0]    mem_be_o,
    input logic                mem_ack_i,
    input logic                done_o
);
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
            && $stable(mem_wdata_o) && $stable(mem_be_o)); // R7
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ack_i |=> done_o && !mem_req_o); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !mem_req_o); // R9
    AST_PLAIN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o && req_mode_i == 2'd0
            |=> mem_req_o && mem_be_o == {LANES{1'b1}}); // R1
    AST_MASK_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o && req_mode_i == 2'd1
            |=> mem_be_o[0] == $past(req_sel_i[LANES-1])); // R3
    AST_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_ready_o && req_mode_i == 2'd3 && req_sel_i == '0
            |=> mem_be_o == '0); // R5
endmodule

bind qstore_unit qstore_unit_chk #(.AW(AW), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_mode_i  (req_mode_i),
    .req_sel_i   (req_sel_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_be_o    (mem_be_o),
    .mem_ack_i   (mem_ack_i),
    .done_o      (done_o)
);

// File: tb/qstore_unit_tb.sv
`timescale 1ns/1ps
module qstore_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [1:0]  req_mode_i = '0;
    logic [31:0] req_addr_i = '0;
    logic [63:0] req_data_i = '0;
    logic [63:0] req_sel_i = '0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic [63:0] mem_wdata_o;
    logic [7:0]  mem_be_o;
    logic        mem_ack_i = 1'b0;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] mem [0:63];
    logic [7:0] shadow [0:63];

    always #5 clk = ~clk;

    qstore_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_mode_i(req_mode_i), .req_addr_i(req_addr_i), .req_data_i(req_data_i),
        .req_sel_i(req_sel_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .mem_ack_i(mem_ack_i),
        .done_o(done_o)
    );

    // memory model: write enabled lanes on an acknowledged request
    always @(posedge clk) begin
        if (mem_req_o && mem_ack_i) begin
            for (int i = 0; i < 8; i++)
                if (mem_be_o[i]) mem[{mem_addr_o[5:3], 3'(i)}] = mem_wdata_o[8*i +: 8];
        end
    end

    // random acknowledge latency, driven just after the edge
    always begin
        @(posedge clk);
        #1;
        mem_ack_i = mem_req_o && ($urandom % 3 != 0);
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] f_be(input logic [1:0] m, input logic [63:0] s);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) begin
            case (m)
                2'd0: b[i] = 1'b1;
                2'd1: b[i] = s[7-i];
                2'd2: b[i] = ~s[8*(7-i)];
                default: b[i] = (s >= 64'd8) || (64'(i) < s);
            endcase
        end
        return b;
    endfunction

    function automatic logic [63:0] f_lanes(input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
        return r;
    endfunction

    task automatic do_store(input logic [1:0] m, input logic [2:0] slot,
                            input logic [63:0] d, input logic [63:0] s, input string tag);
        logic [7:0]  eb;
        logic [63:0] ew;
        logic [31:0] ea;
        bit prev_fire;
        bit got_done;
        eb = f_be(m, s);
        ew = f_lanes(d);
        ea = {26'h155, slot, 3'b000};
        @(negedge clk);
        req_valid_i = 1'b1; req_mode_i = m; req_addr_i = ea; req_data_i = d; req_sel_i = s;
        @(negedge clk);
        req_valid_i = 1'b0;
        prev_fire = 0;
        got_done = 0;
        for (int t = 0; t < 40 && !got_done; t++) begin
            if (prev_fire) begin
                check(done_o == 1'b1, "R8 done after ack", 64'(done_o), 64'd1);
                check(mem_req_o == 1'b0, "R8 req low at done", 64'(mem_req_o), 64'd0);
            end
            if (done_o) begin
                got_done = 1;
            end else if (mem_req_o) begin
                check(mem_be_o == eb, {tag, " byte enables"}, 64'(mem_be_o), 64'(eb));
                check(mem_wdata_o == ew, "R2 lane data", mem_wdata_o, ew);
                check(mem_addr_o == ea, "R7 address held", 64'(mem_addr_o), 64'(ea));
                check(req_ready_o == 1'b0, "R9 ready low while busy", 64'(req_ready_o), 64'd0);
                prev_fire = mem_ack_i;
                @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end
        check(got_done, "R8 done seen", 64'(got_done), 64'd1);
        for (int i = 0; i < 8; i++)
            if (eb[i]) shadow[{slot, 3'(i)}] = d[8*(7-i) +: 8];
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", 64'(done_o), 64'd0);
        check(req_ready_o == 1'b1, "R9 ready after done", 64'(req_ready_o), 64'd1);
        for (int i = 0; i < 8; i++)
            check(mem[{slot, 3'(i)}] == shadow[{slot, 3'(i)}], {tag, " R6 memory byte"},
                  64'(mem[{slot, 3'(i)}]), 64'(shadow[{slot, 3'(i)}]));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'hEE ^ 8'(i);
            shadow[i] = 8'hEE ^ 8'(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_req_o == 1'b0, "reset req", 64'(mem_req_o), 64'd0);
        check(done_o == 1'b0, "reset done", 64'(done_o), 64'd0);
        check(req_ready_o == 1'b1, "R9 reset ready", 64'(req_ready_o), 64'd1);

        do_store(2'd0, 3'd0, 64'h0123456789ABCDEF, 64'h0, "R1 plain");
        do_store(2'd1, 3'd1, 64'h1234123412341234, 64'hB7, "R3 mask B7");
        do_store(2'd1, 3'd2, 64'h0000000000AABBCC, 64'h07, "R3 mask 07");
        do_store(2'd1, 3'd3, 64'hFFFFFFFFFFFFFFFF, 64'h00, "R3 mask none");
        do_store(2'd2, 3'd4, 64'h1234123412341234, 64'h0000000000010101, "R4 inverted");
        do_store(2'd2, 3'd5, 64'h8877665544332211, 64'hFEFEFEFEFEFEFEFE, "R4 inverted all");
        do_store(2'd3, 3'd6, 64'h4567456745674567, 64'd6, "R5 count 6");
        do_store(2'd3, 3'd7, 64'h1234123412341234, 64'd3, "R5 count 3");
        do_store(2'd3, 3'd0, 64'hDEADBEEFDEADBEEF, 64'd0, "R5 count 0");
        do_store(2'd3, 3'd1, 64'hCAFEF00DCAFEF00D, 64'd8, "R5 count 8");
        do_store(2'd3, 3'd2, 64'h0102030405060708, 64'h100000000000002, "R5 count huge");

        for (int n = 0; n < 150; n++) begin
            logic [1:0]  m;
            logic [63:0] s;
            m = 2'($urandom);
            s = {$urandom, $urandom};
            if (m == 2'd3 && ($urandom % 4 != 0)) s = 64'($urandom % 11);
            do_store(m, 3'($urandom), {$urandom, $urandom}, s, "R2 random");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule